// File: doc/BRIEF.md
# Serial Memory Command and Write-Protection Logic

This block sits in front of a 128K-byte serial memory array and decides what may be written. It watches an SPI bus in mode 0, oversampled by the system clock, and decodes four commands: set the write-enable latch, clear it, read the status byte, and write the status byte. It holds the write-enable latch, a protect-enable bit and a two-bit block-protect field. It combines these with an active-low hardware protect pin into two permits. One permit is for status updates. The other is for a memory write at a given 17-bit address.

Protection works at two levels. The block-protect field locks a fixed region of the array: nothing, the upper quarter, the upper half, or all of it. The protect-enable bit decides whether the hardware pin can freeze the status byte. All state changes wait until chip select rises at the end of a frame of exactly the right length. Frames that are cut short, too long or unknown leave the state as it was. The block-protect and protect-enable bits are plain registers that reset to zero.

Top module: `wpc_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 40h, spi_miso is 0, and both status_wr_ok and mem_wr_ok are 0.
- R2: Opcode 05h (status read) shifts the status byte out on spi_miso, MSB first, changing after each falling SCK edge. It starts at the first falling edge after the opcode and repeats for as long as chip select stays low. Status layout: bit 7 = protect enable, bit 6 = 1, bits 5 and 4 = 0, bits 3:2 = block-protect field, bit 1 = write-enable latch, bit 0 = 0. The command changes no state, and spi_miso is 0 while chip select is high.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it. Each needs a frame of exactly 8 bits, sampled MSB first on rising SCK, and takes effect when chip select rises.
- R4: Opcode 01h followed by one data byte, in a frame of exactly 16 bits, writes data bit 7 to protect enable and data bits 3:2 to the block-protect field. The other data bits, including bit 1, are ignored. This happens only when the status write is permitted.
- R5: A status write frame issued while the latch is 0 leaves the status byte unchanged.
- R6: A complete 16-bit status write frame always clears the write-enable latch, whether or not the status was updated.
- R7: status_wr_ok = latch AND NOT (protect enable AND NOT wp_n). With protect enable = 0 the pin is ignored. With protect enable = 1 and wp_n low, status writes are blocked.
- R8: mem_wr_ok is 1 only when the latch is 1 and wr_addr is outside the locked region. The locked region by block-protect field: 00 none, 01 18000h–1FFFFh, 10 10000h–1FFFFh, 11 00000h–1FFFFh.
- R9: Frames that are shorter or longer than their command needs, and unknown opcodes, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data in |
| spi_miso | output | 1 | SPI data out (status byte) |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| wr_addr | input | 17 | Address of a pending memory write |
| status_wr_ok | output | 1 | Status write currently permitted |
| mem_wr_ok | output | 1 | Memory write to wr_addr permitted |

## Verification
SPI pins pass through one register stage before edge detection. As a result, latch and status updates appear on the second clock edge after chip select rises, and spi_miso changes on the second clock edge after a falling SCK. Both permits are combinational from the state, wp_n and wr_addr. The bench holds every SPI phase for four clocks and reads each spi_miso bit just before the next rising SCK. It also waits four clocks after chip select rises before it reads the status back over the bus or checks the permits. This keeps every sample clear of an update in flight.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CNT_W     = $clog2(2 * BYTE_W + 2);
    localparam int unsigned IDX_W     = $clog2(BYTE_W);
    localparam int unsigned BIT_PEN   = 7;
    localparam int unsigned BIT_BP_HI = 3;
    localparam int unsigned BIT_BP_LO = 2;

    typedef enum logic [BYTE_W-1:0] {
        OP_WRSR = 8'h01,
        OP_WRDI = 8'h04,
        OP_RDSR = 8'h05,
        OP_WREN = 8'h06
    } opcode_e;

    typedef struct packed {
        logic       pen;
        logic [1:0] bp;
        logic       wel;
    } prot_state_t;

    function automatic logic [BYTE_W-1:0] status_pack(input prot_state_t s);
        return {s.pen, 1'b1, 2'b00, s.bp, s.wel, 1'b0};
    endfunction
endpackage

// File: rtl/wpc_pin_sampler.sv
module wpc_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_low,
    output logic mosi_s
);
    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
        logic sck_prev;
        logic cs_n_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d           = smp_q;
        smp_d.sck       = sck_in;
        smp_d.cs_n      = cs_n_in;
        smp_d.mosi      = mosi_in;
        smp_d.sck_prev  = smp_q.sck;
        smp_d.cs_n_prev = smp_q.cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0, sck_prev: 1'b0, cs_n_prev: 1'b1};
        else        smp_q <= smp_d;
    end

    assign sck_rise = smp_q.sck & ~smp_q.sck_prev;
    assign sck_fall = ~smp_q.sck & smp_q.sck_prev;
    assign cs_rise  = smp_q.cs_n & ~smp_q.cs_n_prev;
    assign cs_low   = ~smp_q.cs_n;
    assign mosi_s   = smp_q.mosi;
endmodule

// File: rtl/wpc_frame.sv
module wpc_frame
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_rise,
    input  logic              cs_low,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              done,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [BYTE_W-1:0] opcode,
    output logic [BYTE_W-1:0] data,
    output logic              miso
);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;
    localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(2 * BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] dat;
        logic              rd_act;
        logic [IDX_W-1:0]  tx_idx;
        logic              tx_bit;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        frm_d   = frm_q;
        shifted = {frm_q.shreg[BYTE_W-2:0], mosi_s};
        if (!cs_low) begin
            // Idle or end of frame: restart decoding, release the output.
            frm_d.cnt    = '0;
            frm_d.rd_act = 1'b0;
            frm_d.tx_idx = '0;
            frm_d.tx_bit = 1'b0;
        end else begin
            if (sck_rise) begin
                frm_d.shreg = shifted;
                if (frm_q.cnt != CNT_SAT) frm_d.cnt = frm_q.cnt + CNT_W'(1);
                if (frm_q.cnt == CNT_OP) begin
                    frm_d.op     = shifted;
                    frm_d.rd_act = (shifted == OP_RDSR);
                    frm_d.tx_idx = '0;
                end
                if (frm_q.cnt == CNT_DATA) frm_d.dat = shifted;
            end
            if (sck_fall && frm_q.rd_act) begin
                // Index counts up from the MSB; wraps so the byte repeats.
                frm_d.tx_bit = status_byte[~frm_q.tx_idx];
                frm_d.tx_idx = frm_q.tx_idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    assign done    = cs_rise;
    assign bit_cnt = frm_q.cnt;
    assign opcode  = frm_q.op;
    assign data    = frm_q.dat;
    assign miso    = frm_q.tx_bit;
endmodule

// File: rtl/wpc_prot_map.sv
module wpc_prot_map #(
    parameter int unsigned ADDR_W = 17
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    logic upper_half;
    logic upper_quarter;

    assign upper_half    = addr[ADDR_W-1];
    assign upper_quarter = &addr[ADDR_W-1:ADDR_W-2];

    always_comb begin
        unique case (bp)
            2'b00:   locked = 1'b0;
            2'b01:   locked = upper_quarter;
            2'b10:   locked = upper_half;
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpc_wp_ctrl.sv
module wpc_wp_ctrl
    import wpc_pkg::*;
#(
    parameter int unsigned ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              status_wr_ok,
    output logic              mem_wr_ok
);
    localparam logic [CNT_W-1:0] LEN_CMD = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LEN_WR  = CNT_W'(2 * BYTE_W);

    logic              sck_rise, sck_fall, cs_rise, cs_low, mosi_s;
    logic              frm_done;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] opcode, data, status_byte;
    logic              locked, st_gate;

    prot_state_t st_d, st_q;

    wpc_pin_sampler i_sampler (
        .clk(clk), .rst_n(rst_n),
        .sck_in(spi_sck), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cs_low(cs_low), .mosi_s(mosi_s)
    );

    wpc_frame i_frame (
        .clk(clk), .rst_n(rst_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cs_low(cs_low), .mosi_s(mosi_s), .status_byte(status_byte),
        .done(frm_done), .bit_cnt(bit_cnt), .opcode(opcode), .data(data),
        .miso(spi_miso)
    );

    wpc_prot_map #(.ADDR_W(ADDR_W)) i_map (
        .bp(st_q.bp), .addr(wr_addr), .locked(locked)
    );

    assign status_byte = status_pack(st_q);
    assign st_gate     = ~(st_q.pen & ~wp_n);

    always_comb begin
        st_d = st_q;
        if (frm_done) begin
            if (bit_cnt == LEN_CMD && opcode == OP_WREN) st_d.wel = 1'b1;
            if (bit_cnt == LEN_CMD && opcode == OP_WRDI) st_d.wel = 1'b0;
            if (bit_cnt == LEN_WR && opcode == OP_WRSR) begin
                st_d.wel = 1'b0;
                if (st_q.wel && st_gate) begin
                    st_d.pen = data[BIT_PEN];
                    st_d.bp  = data[BIT_BP_HI:BIT_BP_LO];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_wr_ok = st_q.wel & st_gate;
    assign mem_wr_ok    = st_q.wel & ~locked;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic       wp_n,
    input logic       mem_wr_ok,
    input logic       frm_done,
    input logic       wel,
    input logic       pen,
    input logic [1:0] bp
);
    assert_miso_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n, 2) |-> !spi_miso);

    assert_latch_by_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wel) |-> $past(frm_done));

    assert_status_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(bp) || !$stable(pen)) |-> $past(wel));

    assert_pin_freezes_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pen) && !$past(wp_n)) |-> ($stable(bp) && $stable(pen)));

    assert_full_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp == 2'b11) |-> !mem_wr_ok);

    assert_no_latch_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |-> !mem_wr_ok);
endmodule

bind wpc_wp_ctrl wpc_checker i_wpc_checker (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .wp_n(wp_n), .mem_wr_ok(mem_wr_ok), .frm_done(frm_done),
    .wel(st_q.wel), .pen(st_q.pen), .bp(st_q.bp)
);

// File: tb/test_wpc_wp_ctrl.sv
module test_wpc_wp_ctrl;
    localparam int HALF = 4;
    localparam int NVEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic        miso, swok, mwok;
    logic [16:0] addr = '0;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    wpc_wp_ctrl i_wpc_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n), .wr_addr(addr),
        .status_wr_ok(swok), .mem_wr_ok(mwok)
    );

    // {opcode, data, bit count, wp_n, expected status, requirement}
    localparam logic [33:0] VEC [0:NVEC-1] = '{
        {8'h06, 8'h00, 5'd8,  1'b1, 8'h42, 4'd3},  // R3 set latch
        {8'h04, 8'h00, 5'd8,  1'b1, 8'h40, 4'd3},  // R3 clear latch
        {8'h01, 8'h8C, 5'd16, 1'b1, 8'h40, 4'd5},  // R5 no latch
        {8'h06, 8'h00, 5'd8,  1'b1, 8'h42, 4'd3},
        {8'h01, 8'hFF, 5'd16, 1'b1, 8'hCC, 4'd4},  // R4 fixed bits and latch bit ignored
        {8'h06, 8'h00, 5'd8,  1'b1, 8'hCE, 4'd3},
        {8'h01, 8'h04, 5'd16, 1'b0, 8'hCC, 4'd7},  // R7 pin blocks, R6 latch cleared
        {8'h06, 8'h00, 5'd8,  1'b0, 8'hCE, 4'd3},
        {8'h01, 8'h04, 5'd16, 1'b1, 8'h44, 4'd4},  // R4
        {8'h06, 8'h00, 5'd7,  1'b1, 8'h44, 4'd9},  // R9 short
        {8'h06, 8'h00, 5'd9,  1'b1, 8'h44, 4'd9},  // R9 long
        {8'hA5, 8'h00, 5'd8,  1'b1, 8'h44, 4'd9},  // R9 unknown
        {8'h06, 8'h00, 5'd8,  1'b1, 8'h46, 4'd3},
        {8'h01, 8'h08, 5'd15, 1'b1, 8'h46, 4'd9},  // R9 short status write
        {8'h01, 8'h08, 5'd16, 1'b0, 8'h48, 4'd7},  // R7 pin ignored
        {8'h06, 8'h00, 5'd8,  1'b1, 8'h4A, 4'd3},
        {8'h05, 8'h00, 5'd8,  1'b1, 8'h4A, 4'd2},  // R2 no side effect
        {8'h01, 8'h08, 5'd17, 1'b1, 8'h4A, 4'd9},  // R9 long status write
        {8'h04, 8'h00, 5'd8,  1'b1, 8'h48, 4'd3},
        {8'h01, 8'h00, 5'd16, 1'b1, 8'h48, 4'd6}   // R6 latch stays clear
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [23:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? tx[23-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i >= 8) rx = {rx[14:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] st);
        logic [15:0] rx;
        frame({8'h05, 16'h0}, 16, rx);
        st = rx[7:0];
    endtask

    task automatic set_bp(input logic [1:0] bp);
        logic [15:0] rx;
        frame({8'h06, 16'h0}, 8, rx);
        frame({8'h01, 4'h0, bp, 2'b00, 8'h00}, 16, rx);
        frame({8'h06, 16'h0}, 8, rx);
    endtask

    function automatic logic exp_mem(input logic wel, input logic [1:0] bp, input logic [16:0] a);
        logic lk;
        lk = (bp == 2'b11) || (bp == 2'b10 && a >= 17'h10000) || (bp == 2'b01 && a >= 17'h18000);
        return wel && !lk;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  st;
        logic [15:0] rx;
        logic [16:0] addrs [0:5];
        addrs = '{17'h00000, 17'h0FFFF, 17'h10000, 17'h17FFF, 17'h18000, 17'h1FFFF};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 miso", 32'(miso), 0);
        check("R1 status_wr_ok", 32'(swok), 0);
        check("R1 mem_wr_ok", 32'(mwok), 0);
        read_status(st);
        check("R1 status", 32'(st), 32'h40);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] op, dat, exp;
            logic [4:0] nb;
            logic [3:0] rq;
            {op, dat, nb, wp_n, exp, rq} = VEC[v];
            frame({op, dat, 8'h00}, int'(nb), rx);
            read_status(st);
            check($sformatf("R%0d vector %0d status", rq, v), 32'(st), 32'(exp));
            check($sformatf("R7 vector %0d status_wr_ok", v), 32'(swok),
                  32'(exp[1] & ~(exp[7] & ~wp_n)));
        end
        wp_n = 1'b1;

        // R2: byte repeats while chip select stays low
        frame({8'h05, 16'h0}, 24, rx);
        check("R2 first copy", 32'(rx[15:8]), 32'h48);
        check("R2 repeated copy", 32'(rx[7:0]), 32'h48);
        check("R2 miso idle", 32'(miso), 0);

        // R8: locked region per block-protect setting
        for (int b = 0; b < 4; b++) begin
            set_bp(2'(b));
            for (int k = 0; k < 6; k++) begin
                addr = addrs[k];
                @(negedge clk);
                check($sformatf("R8 bp=%0d addr=%0h", b, addrs[k]), 32'(mwok),
                      32'(exp_mem(1'b1, 2'(b), addrs[k])));
            end
        end
        set_bp(2'b00);
        frame({8'h04, 16'h0}, 8, rx);
        addr = 17'h00010;
        @(negedge clk);
        check("R8 latch clear", 32'(mwok), 0);

        // R7: protect enable with pin toggled live
        frame({8'h06, 16'h0}, 8, rx);
        frame({8'h01, 8'h80, 8'h00}, 16, rx);
        frame({8'h06, 16'h0}, 8, rx);
        wp_n = 1'b0;
        @(negedge clk);
        check("R7 pin low blocks", 32'(swok), 0);
        wp_n = 1'b1;
        @(negedge clk);
        check("R7 pin high permits", 32'(swok), 1);
        read_status(st);
        check("R4 protect enable set", 32'(st), 32'hC2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule